// File: doc/BRIEF.md
# General-Purpose I/O Bank with Set/Clear Output Aliases

This block is a bank of general-purpose pins with a small word-wide register interface. Software picks each pin's direction and drives output levels. It reads back the pad levels through a synchronizer. The output latch can be changed as a whole word. Two write-only aliases also change it: one turns on the bits written as 1, and the other turns off the bits written as 1. This lets a single pin change without a read-modify-write sequence.

The pad side is modelled as three vectors: one drive-enable vector, one drive-value vector, and the sampled pad input. A control bit puts the bank into an off state. In that state, input sampling stops while all register accesses keep working. A read-only identification word reports a major and a minor version.

Register selection uses a 3-bit word address:

| Address | Register |
|---|---|
| 0 | version (read-only) |
| 1 | control |
| 2 | direction |
| 3 | input data (read-only) |
| 4 | output data |
| 5 | set alias |
| 6 | clear alias |
| 7 | unused: reads 0, writes have no effect |

Reads are combinational from the address. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, the direction register is all ones, the output latch is zero, and the control register is zero. As a result, `pad_oe` is all zeros and `pad_out` is all zeros.
- R2: A 1 in the direction register (address 2) makes that pin an input (`pad_oe` bit = 0). A 0 makes it an output (`pad_oe` bit = 1). The change is visible right after the write edge.
- R3: A write to address 5 sets every output-latch bit where the written word is 1 and leaves all other bits unchanged.
- R4: A write to address 6 clears every output-latch bit where the written word is 1 and leaves all other bits unchanged.
- R5: Address 4 reads and writes the output latch as a full word, and `pad_out` always equals the output latch.
- R6: Control bit 0 (address 1) set to 1 puts the bank off. While it is set, the input-data value holds still, but register reads and writes still take effect.
- R7: Address 0 reads the major version in bits [7:4] and the minor version in bits [3:0] (values 2 and 1, so the word is 0x21). All other bits read 0.
- R8: With the bank on, a pad level appears in the input-data register (address 3) two clock edges after it is applied.
- R9: Reading address 5 or address 6 returns the current output-latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | N_PINS | Pad levels from the pins |
| pad_oe | output | N_PINS | Drive enable per pin (1 = drive) |
| pad_out | output | N_PINS | Drive value per pin |

## Verification
Input sampling and writes to the off bit can land on the same clock edge. The bench provokes this by changing `pad_in` in the same cycle that the control word is written, in both directions. It then judges the input-data value over the following edges against a behavioural model. In that model, sampling at an edge obeys the control value held before the edge. This means the pad change caught on the turn-off edge reaches stage one but never reaches the register until the bank is turned back on. Randomised traffic on every address, with pads toggling, is then compared against the same model on each clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [3:0] VER_MAJOR = 4'd2;
    localparam logic [3:0] VER_MINOR = 4'd1;

    localparam int OFF_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        SEL_VER  = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_DIR  = 3'd2,
        SEL_DIN  = 3'd3,
        SEL_DOUT = 3'd4,
        SEL_SET  = 3'd5,
        SEL_CLR  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [BUS_W-1:0] data;
    } bus_cmd_t;

    function automatic bus_cmd_t make_cmd(input logic wr,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [BUS_W-1:0] data);
        bus_cmd_t c;
        c.wr   = wr;
        c.sel  = reg_sel_e'(addr);
        c.data = data;
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] version_word();
        return {{(BUS_W-8){1'b0}}, VER_MAJOR, VER_MINOR};
    endfunction

endpackage

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
    import gpio_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] dout_q,
    output logic              off_q
);

    logic [N_PINS-1:0] wval;
    assign wval = cmd.data[N_PINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            dout_q <= '0;
            off_q  <= 1'b0;
        end else if (cmd.wr) begin
            case (cmd.sel)
                SEL_CTRL: off_q  <= cmd.data[OFF_BIT];
                SEL_DIR:  dir_q  <= wval;
                SEL_DOUT: dout_q <= wval;
                SEL_SET:  dout_q <= dout_q | wval;
                SEL_CLR:  dout_q <= dout_q & ~wval;
                default: ;
            endcase
        end
    end

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_SET) |=> dout_q == ($past(dout_q) | $past(wval))); // R3
    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_CLR) |=> dout_q == ($past(dout_q) & ~$past(wval))); // R4
    AST_DOUT_WORD: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_DOUT) |=> dout_q == $past(wval)); // R5
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && (cmd.sel == SEL_DOUT || cmd.sel == SEL_SET || cmd.sel == SEL_CLR))
        |=> $stable(dout_q)); // R5
    AST_DIR_WORD: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_DIR) |=> dir_q == $past(wval)); // R2

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N_PINS = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] sampled
);

    logic [N_PINS-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic [N_PINS-1:0] src;
            if (i == 0) begin : g_first
                assign src = pad_in;
            end else begin : g_next
                assign src = stg[i-1];
            end
            always_ff @(posedge clk) begin
                if (rst)        stg[i] <= '0;
                else if (!hold) stg[i] <= src;
            end
        end
    endgenerate

    assign sampled = stg[STAGES-1];

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(sampled)); // R6
    AST_LAST_STAGE: assert property (@(posedge clk) disable iff (rst)
        !hold |=> sampled == $past(stg[STAGES-2])); // R8

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int N_PINS      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out
);

    bus_cmd_t          cmd;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] dout_q;
    logic [N_PINS-1:0] din_q;
    logic              off_q;

    assign cmd = make_cmd(bus_wr, bus_addr, bus_wdata);

    gpio_ctl_regs #(.N_PINS(N_PINS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .dir_q  (dir_q),
        .dout_q (dout_q),
        .off_q  (off_q)
    );

    gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .hold    (off_q),
        .pad_in  (pad_in),
        .sampled (din_q)
    );

    assign pad_oe  = ~dir_q;
    assign pad_out = dout_q;

    always_comb begin
        case (cmd.sel)
            SEL_VER:  bus_rdata = version_word();
            SEL_CTRL: bus_rdata = {{(BUS_W-1){1'b0}}, off_q};
            SEL_DIR:  bus_rdata = BUS_W'(dir_q);
            SEL_DIN:  bus_rdata = BUS_W'(din_q);
            SEL_DOUT,
            SEL_SET,
            SEL_CLR:  bus_rdata = BUS_W'(dout_q);
            default:  bus_rdata = '0;
        endcase
    end

    AST_ALIAS_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd5 || bus_addr == 3'd6) |-> bus_rdata == BUS_W'(pad_out)); // R9
    AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd2) |-> bus_rdata == BUS_W'(~pad_oe)); // R2

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    gpio_bank dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    always #5 clk = ~clk;

    // behavioural reference
    logic [31:0] m_dir, m_dout, m_s1, m_s2;
    bit          m_off;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return 32'h21;
            3'd1: return {31'd0, m_off};
            3'd2: return m_dir;
            3'd3: return m_s2;
            3'd4, 3'd5, 3'd6: return m_dout;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R7 version";
            3'd1: return "R6 control";
            3'd2: return "R2 direction";
            3'd3: return "R8 input data";
            3'd4: return "R5 output latch";
            3'd5, 3'd6: return "R9 alias read";
            default: return "R7 unused address";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dir = '1; m_dout = '0; m_off = 0; m_s1 = '0; m_s2 = '0;
        end else begin
            if (!m_off) begin
                m_s2 = m_s1;
                m_s1 = pad_in;
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd1: m_off  = bus_wdata[0];
                    3'd2: m_dir  = bus_wdata;
                    3'd4: m_dout = bus_wdata;
                    3'd5: m_dout = m_dout | bus_wdata;
                    3'd6: m_dout = m_dout & ~bus_wdata;
                    default: ;
                endcase
            end
        end
        #2;
        check("R2 pad_oe", pad_oe, ~m_dir);
        check("R5 pad_out", pad_out, m_dout);
        check(read_tag(bus_addr), bus_rdata, m_read(bus_addr));
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 pad_out after reset", pad_out, 32'h0);
        rd_chk("R1 direction reset", 3'd2, 32'hFFFF_FFFF);
        rd_chk("R1 control reset", 3'd1, 32'h0);
        rd_chk("R7 version word", 3'd0, 32'h0000_0021);
        rd_chk("R7 unused address", 3'd7, 32'h0);
        @(negedge clk);

        wr(3'd2, 32'hFFFF_0000);
        check("R2 direction low half output", pad_oe, 32'h0000_FFFF);
        wr(3'd4, 32'h1234_5678);
        check("R5 full word write", pad_out, 32'h1234_5678);
        wr(3'd5, 32'h0000_000F);
        check("R3 set alias", pad_out, 32'h1234_567F);
        wr(3'd6, 32'h0000_0070);
        check("R4 clear alias", pad_out, 32'h1234_560F);
        wr(3'd5, 32'h0);
        check("R3 set with zero word", pad_out, 32'h1234_560F);
        wr(3'd6, 32'h0);
        check("R4 clear with zero word", pad_out, 32'h1234_560F);
        wr(3'd7, 32'hFFFF_FFFF);
        check("R5 unused write no effect", pad_out, 32'h1234_560F);
        rd_chk("R9 set alias read", 3'd5, 32'h1234_560F);
        rd_chk("R9 clear alias read", 3'd6, 32'h1234_560F);

        // R8 two-edge latency
        bus_addr = 3'd3;
        pad_in = 32'hA5A5_A5A5;
        @(negedge clk);
        check("R8 not yet after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        check("R8 visible after two edges", bus_rdata, 32'hA5A5_A5A5);

        // R6 turn off while the pad changes in the same cycle
        pad_in = 32'h5A5A_5A5A;
        wr(3'd1, 32'h1);
        repeat (4) @(negedge clk);
        rd_chk("R6 input frozen while off", 3'd3, 32'hA5A5_A5A5);
        wr(3'd5, 32'hF000_0000);
        check("R6 writes work while off", pad_out, 32'hF234_560F);
        pad_in = 32'h0F0F_0F0F;
        wr(3'd1, 32'h0);
        rd_chk("R6 stage-one value after turn-on edge", 3'd3, 32'hA5A5_A5A5);
        @(negedge clk);
        rd_chk("R6 resume with captured value", 3'd3, 32'h5A5A_5A5A);
        @(negedge clk);
        rd_chk("R8 resume tracking", 3'd3, 32'h0F0F_0F0F);

        // randomised traffic compared every clock
        for (int i = 0; i < 400; i++) begin
            bus_wr    = ($urandom_range(0, 2) != 0);
            bus_addr  = 3'($urandom_range(0, 7));
            bus_wdata = $urandom;
            if (bus_addr == 3'd1) bus_wdata[0] = ($urandom_range(0, 3) == 0);
            pad_in    = $urandom;
            @(negedge clk);
        end
        bus_wr = 1'b0;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule